// File: doc/BRIEF.md
# Dual Data Pointer with Post-Access Modes

This block holds two 24-bit data pointers, a main one and a shadow one, for a core that moves data to and from a large data memory. Each pointer is built from three bytes: low, high and page. A control register chooses which pointer drives the address output. It gives each pointer its own post-access behaviour, and it can make the active pointer swap after every data access. The result is that a copy loop can alternate between a source pointer and a destination pointer with no instructions spent on pointer bookkeeping.

The core writes the pointer bytes and the control register through a plain register port. It signals the end of each data-move access with a one-cycle strobe and can issue a separate pointer-increment command. Reads of the same register space are combinational. All updates take effect on the rising clock edge on which they are presented. The address output always shows the pointer that is active at that moment. None of the inputs has back-pressure: every strobe is taken in the cycle it is presented, and there is no valid/ready handshake.

Top module: `dptr_dual`

## Requirements
- R1: After reset both pointers are zero, the address output is 0, and the control register reads 0x00 (main pointer active, both modes plain, auto-swap off).
- R2: The select bit chooses the active pointer (0 = main, 1 = shadow), and the address output shows that pointer. A register write to address 0, 1 or 2 loads the low, high or page byte of the active pointer only, and a read of those addresses returns the active pointer's byte.
- R3: The control register sits at address 3 with this layout: bit 0 is the select bit, bits 3:2 are the main pointer's mode, bits 5:4 are the shadow pointer's mode, and bit 6 enables auto-swap. Bits 1 and 7 are not stored and always read 0. The mode codes are 0 = plain, 1 = post-increment, 2 = post-decrement and 3 = toggle the address LSB.
- R4: Writing back the control value read plus one toggles the select bit and leaves the mode fields and the auto-swap bit unchanged.
- R5: An access-done strobe while the active pointer's mode is plain leaves that pointer unchanged.
- R6: With mode post-increment, an access-done strobe adds 1 to the full 24-bit active pointer, carrying across bytes and wrapping from 0xFFFFFF to 0x000000.
- R7: With mode post-decrement, an access-done strobe subtracts 1 from the full 24-bit active pointer, borrowing across bytes and wrapping from 0x000000 to 0xFFFFFF.
- R8: With mode LSB-toggle, an access-done strobe inverts bit 0 of the active pointer and leaves the other 23 bits unchanged.
- R9: An access modifies only the active pointer, and it applies that pointer's own mode field.
- R10: With auto-swap enabled, an access-done strobe flips the select bit on the same clock edge. The modify step is applied to the pointer that was active before the flip.
- R11: The increment command adds 1 to the full 24-bit active pointer in any mode and never flips the select bit.
- R12: When events coincide in one cycle, a register write wins over the increment command, which wins over access-done; the losing events have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address (0 low, 1 high, 2 page, 3 control) |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address, same map |
| rd_data | output | 8 | Combinational read data (0 for unmapped addresses) |
| access_done | input | 1 | One-cycle strobe at the end of a data-move access |
| inc_ptr | input | 1 | Increment the active pointer by one |
| addr_o | output | 24 | Currently active 24-bit address |

## Verification
The assertions watch every cycle for the modify rules of a lone access: an unchanged pointer in plain mode, and +1 or -1 on the full address in the increment and decrement modes. They also check that a strobe with auto-swap enabled flips the select bit, that the increment command adds one without a swap, and that a cycle with no events changes nothing. Only the bench scenarios can show the following: byte writes and reads reaching the selected pointer and no other, the wrap at both ends of the range, the LSB toggle, each pointer keeping its own mode across a swap, the read-plus-one trick on the control register, and the priority among coinciding events.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_INC   = 2'd1,
    MODE_DEC   = 2'd2,
    MODE_LSB   = 2'd3
  } dptr_mode_e;

  typedef struct packed {
    logic       auto_tog;
    dptr_mode_e mode_shd;
    dptr_mode_e mode_main;
    logic       sel;
  } dptr_ctrl_t;
endpackage

// File: rtl/dptr_step.sv
module dptr_step
  import dptr_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] cur,
  input  dptr_mode_e    mode,
  input  logic          force_inc,
  output logic [AW-1:0] nxt
);
  always_comb begin
    if (force_inc) begin
      nxt = cur + AW'(1);
    end else begin
      unique case (mode)
        MODE_INC: nxt = cur + AW'(1);
        MODE_DEC: nxt = cur - AW'(1);
        MODE_LSB: nxt = {cur[AW-1:1], ~cur[0]};
        default:  nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [1:0]        wr_mode_main,
  input  logic [1:0]        wr_mode_shd,
  input  logic              wr_tog,
  input  logic              flip,
  output dptr_ctrl_t        ctrl_q,
  output logic [BYTE_W-1:0] ctrl_rd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{auto_tog: 1'b0, mode_shd: MODE_PLAIN, mode_main: MODE_PLAIN, sel: 1'b0};
    end else if (wr_en) begin
      ctrl_q.sel       <= wr_sel;
      ctrl_q.mode_main <= dptr_mode_e'(wr_mode_main);
      ctrl_q.mode_shd  <= dptr_mode_e'(wr_mode_shd);
      ctrl_q.auto_tog  <= wr_tog;
    end else if (flip) begin
      ctrl_q.sel <= ~ctrl_q.sel;
    end
  end

  always_comb begin
    ctrl_rd      = '0;
    ctrl_rd[0]   = ctrl_q.sel;
    ctrl_rd[3:2] = ctrl_q.mode_main;
    ctrl_rd[5:4] = ctrl_q.mode_shd;
    ctrl_rd[6]   = ctrl_q.auto_tog;
  end
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  localparam int AW       = BYTE_W * NUM_BYTES,
  localparam int IW       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic [IW-1:0]     byte_idx,
  input  logic [BYTE_W-1:0] byte_wdata,
  input  logic              upd_en,
  input  logic [AW-1:0]     upd_val,
  output logic [AW-1:0]     q
);
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[b*BYTE_W +: BYTE_W] <= '0;
      end else if (byte_we && (byte_idx == IW'(b))) begin
        q[b*BYTE_W +: BYTE_W] <= byte_wdata;
      end else if (upd_en) begin
        q[b*BYTE_W +: BYTE_W] <= upd_val[b*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/dptr_dual.sv
module dptr_dual
  import dptr_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int REG_AW    = 3,
  localparam int AW       = BYTE_W * NUM_BYTES,
  localparam int IW       = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int CTRL_IDX = NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              access_done,
  input  logic              inc_ptr,
  output logic [AW-1:0]     addr_o
);
  dptr_ctrl_t        ctrl_q;
  logic [BYTE_W-1:0] ctrl_rd;
  logic [AW-1:0]     ptr_q [2];
  logic [AW-1:0]     ptr_nxt;
  dptr_mode_e        act_mode;
  logic              wr_byte, wr_ctrl, do_inc, do_acc, upd, flip;

  // Event priority: write > increment command > access-done.
  assign wr_byte = wr_en && (int'(wr_addr) < NUM_BYTES);
  assign wr_ctrl = wr_en && (int'(wr_addr) == CTRL_IDX);
  assign do_inc  = inc_ptr && !wr_en;
  assign do_acc  = access_done && !wr_en && !inc_ptr;
  assign upd     = do_inc || do_acc;
  assign flip    = do_acc && ctrl_q.auto_tog;

  assign act_mode = ctrl_q.sel ? ctrl_q.mode_shd : ctrl_q.mode_main;
  assign addr_o   = ptr_q[ctrl_q.sel];

  dptr_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_ctrl),
    .wr_sel       (wr_data[0]),
    .wr_mode_main (wr_data[3:2]),
    .wr_mode_shd  (wr_data[5:4]),
    .wr_tog       (wr_data[6]),
    .flip         (flip),
    .ctrl_q       (ctrl_q),
    .ctrl_rd      (ctrl_rd)
  );

  dptr_step #(.AW(AW)) u_step (
    .cur       (addr_o),
    .mode      (act_mode),
    .force_inc (do_inc),
    .nxt       (ptr_nxt)
  );

  for (genvar p = 0; p < 2; p++) begin : g_ptr
    dptr_bank #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_we    (wr_byte && (ctrl_q.sel == 1'(p))),
      .byte_idx   (wr_addr[IW-1:0]),
      .byte_wdata (wr_data),
      .upd_en     (upd && (ctrl_q.sel == 1'(p))),
      .upd_val    (ptr_nxt),
      .q          (ptr_q[p])
    );
  end

  always_comb begin
    if (int'(rd_addr) < NUM_BYTES)
      rd_data = addr_o[rd_addr[IW-1:0]*BYTE_W +: BYTE_W];
    else if (int'(rd_addr) == CTRL_IDX)
      rd_data = ctrl_rd;
    else
      rd_data = '0;
  end

  assert_plain_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_acc && !ctrl_q.auto_tog && act_mode == MODE_PLAIN) |=> $stable(addr_o));

  assert_post_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_acc && !ctrl_q.auto_tog && act_mode == MODE_INC) |=> (addr_o == $past(addr_o) + AW'(1)));

  assert_post_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_acc && !ctrl_q.auto_tog && act_mode == MODE_DEC) |=> (addr_o == $past(addr_o) - AW'(1)));

  assert_auto_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (access_done && !wr_en && !inc_ptr && ctrl_q.auto_tog) |=> (ctrl_q.sel != $past(ctrl_q.sel)));

  assert_inc_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_ptr && !wr_en) |=> ($stable(ctrl_q.sel) && addr_o == $past(addr_o) + AW'(1)));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !inc_ptr && !access_done) |=> ($stable(addr_o) && $stable(ctrl_rd)));
endmodule

// File: tb/dptr_dual_tb.sv
module dptr_dual_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr = 3'd3;
  logic [7:0]  rd_data;
  logic        access_done = 1'b0;
  logic        inc_ptr = 1'b0;
  logic [23:0] addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  // Reference state
  logic [23:0] m_ptr [2];
  logic        m_sel, m_tog;
  logic [1:0]  m_mode [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dptr_dual u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .access_done(access_done),
    .inc_ptr(inc_ptr), .addr_o(addr_o)
  );

  function automatic logic [7:0] m_ctrl();
    return {1'b0, m_tog, m_mode[1], m_mode[0], 1'b0, m_sel};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Driver: one cycle of stimulus, reference update, expectation pushed.
  task automatic cyc(bit we, logic [2:0] wa, logic [7:0] wd, bit acc, bit inc, string tag);
    logic [1:0] md;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; access_done = acc; inc_ptr = inc;
    @(posedge clk);
    #1;
    wr_en = 1'b0; access_done = 1'b0; inc_ptr = 1'b0;
    if (we) begin
      if (wa < 3) m_ptr[m_sel][wa*8 +: 8] = wd;
      else if (wa == 3) begin
        m_sel = wd[0]; m_mode[0] = wd[3:2]; m_mode[1] = wd[5:4]; m_tog = wd[6];
      end
    end else if (inc) begin
      m_ptr[m_sel] = m_ptr[m_sel] + 24'd1;
    end else if (acc) begin
      md = m_mode[m_sel];
      case (md)
        2'd1: m_ptr[m_sel] = m_ptr[m_sel] + 24'd1;
        2'd2: m_ptr[m_sel] = m_ptr[m_sel] - 24'd1;
        2'd3: m_ptr[m_sel][0] = ~m_ptr[m_sel][0];
        default: ;
      endcase
      if (m_tog) m_sel = ~m_sel;
    end
    exp_q.push_back({m_ctrl(), m_ptr[m_sel]});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares the address and control readback against the queue.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {rd_data, addr_o}, e);
    end
  end

  task automatic read_byte(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(tag, {24'd0, rd_data}, {24'd0, exp});
    rd_addr = 3'd3;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    m_ptr[0] = '0; m_ptr[1] = '0; m_sel = 0; m_tog = 0; m_mode[0] = 0; m_mode[1] = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset addr", {8'd0, addr_o}, 32'd0);
    check("R1 reset ctrl", {24'd0, rd_data}, 32'd0);
    rst_n = 1'b1;

    // R2: load both pointers through the select bit
    cyc(1, 3'd0, 8'hFF, 0, 0, "R2 main low");
    cyc(1, 3'd1, 8'hFF, 0, 0, "R2 main high");
    cyc(1, 3'd2, 8'hFF, 0, 0, "R2 main page");
    cyc(1, 3'd3, 8'h01, 0, 0, "R2 select shadow");
    cyc(1, 3'd0, 8'h12, 0, 0, "R2 shd low");
    cyc(1, 3'd1, 8'h34, 0, 0, "R2 shd high");
    cyc(1, 3'd2, 8'h56, 0, 0, "R2 shd page");
    @(negedge clk);
    read_byte(3'd0, 8'h12, "R2 read low");
    read_byte(3'd2, 8'h56, "R2 read page");
    cyc(1, 3'd3, 8'h00, 0, 0, "R2 main kept");

    // R6 increment with wrap
    cyc(1, 3'd3, 8'h04, 0, 0, "R3 mode inc");
    cyc(0, 3'd0, 8'h00, 1, 0, "R6 wrap up");
    cyc(0, 3'd0, 8'h00, 1, 0, "R6 inc");
    // R7 decrement with wrap
    cyc(1, 3'd3, 8'h08, 0, 0, "R3 mode dec");
    cyc(0, 3'd0, 8'h00, 1, 0, "R7 dec");
    cyc(0, 3'd0, 8'h00, 1, 0, "R7 wrap down");
    // R8 LSB toggle
    cyc(1, 3'd3, 8'h0C, 0, 0, "R3 mode lsb");
    cyc(0, 3'd0, 8'h00, 1, 0, "R8 lsb clear");
    cyc(0, 3'd0, 8'h00, 1, 0, "R8 lsb set");
    // R5 plain
    cyc(1, 3'd3, 8'h00, 0, 0, "R3 mode plain");
    cyc(0, 3'd0, 8'h00, 1, 0, "R5 plain hold");

    // R9/R10: per-pointer modes with auto-swap
    cyc(1, 3'd3, 8'h64, 0, 0, "R3 swap cfg");
    cyc(0, 3'd0, 8'h00, 1, 0, "R10 swap to shadow");
    cyc(0, 3'd0, 8'h00, 1, 0, "R9 shadow dec swap back");
    cyc(0, 3'd0, 8'h00, 1, 0, "R10 swap again");
    cyc(1, 3'd3, 8'h64, 0, 0, "R9 main select");

    // R11 increment command: no swap
    cyc(0, 3'd0, 8'h00, 0, 1, "R11 inc cmd");

    // R4 read-plus-one on control
    cyc(1, 3'd3, m_ctrl() + 8'd1, 0, 0, "R4 plus one to shadow");
    cyc(1, 3'd3, m_ctrl() + 8'd1, 0, 0, "R4 plus one to main");
    // R3 unstored bits
    cyc(1, 3'd3, 8'hFF, 0, 0, "R3 unused bits read zero");

    // R12 priority
    cyc(1, 3'd0, 8'hA5, 1, 1, "R12 write wins");
    cyc(0, 3'd0, 8'h00, 1, 1, "R12 inc beats access");
    cyc(1, 3'd5, 8'hFF, 1, 0, "R12 unmapped write blocks access");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule